// File: doc/BRIEF.md
# Pulse-Stream Phase Rotator

This block divides a fast master clock by sixteen and spreads the divided phase over four pulse outputs. Each output fires in turn, one quarter of the divide cycle after the previous one. Two of the outputs carry magnitude timing and two carry polarity timing. A downstream output stage uses these pulse trains as its reference phases. Each pulse lasts one master-clock cycle.

Four control lines move the whole pulse train earlier or later in time. There are two advance lines and two retard lines. A raised advance line injects an extra count into the divider, so the train moves one master clock earlier. A raised retard line swallows one count, so the train moves one master clock later. When both lines of a kind are raised, the shift is two master clocks. The controls are sampled once per control period of sixteen master clocks. They are latched on a free-running sub-harmonic and then passed through successively faster latches down to the master clock. If an advance and a retard land in the same control period, they cancel.

There is no data stream, so there is no valid/ready interface. All pins are plain levels or pulses, and nothing applies back-pressure. The parameter `EQUAL_RATE` chooses between two rates for the polarity outputs. When it is 1, they run at the magnitude rate. When it is 0, they run at half that rate.

Top module: `phase_rotator`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0. After release, the first pulse is on `mag_a`, visible in the cycle that follows the 4th rising clock edge.
- R2: With no control activity, exactly one output pulses every 4 master clocks, in the repeating order `mag_a`, `pol_a`, `mag_b`, `pol_b`.
- R3: An advance request with exactly one of `adv_one`/`adv_two` high moves all later pulses 1 master clock earlier. Exactly one gap between consecutive pulses becomes 3, and the other gaps stay 4.
- R4: A retard request with exactly one of `ret_one`/`ret_two` high moves all later pulses 1 master clock later. Exactly one gap becomes 5.
- R5: With `adv_one` and `adv_two` high together, the stream advances by 2 master clocks. No gap is shorter than 2.
- R6: With `ret_one` and `ret_two` high together, the stream is retarded by 2 master clocks. No gap is longer than 6.
- R7: If any advance line and any retard line are high at the same sampling edge, no shift occurs.
- R8: Control lines are sampled only at the rising edges that are a multiple of 16 after reset release. Levels present at any other edge have no effect on output timing.
- R9: Each magnitude output repeats every 16 master clocks. Each polarity output repeats every 16 master clocks when `EQUAL_RATE`=1 and every 32 master clocks when `EQUAL_RATE`=0.
- R10: Every output pulse is one cycle wide. At most one output is high in any cycle, and no pulse directly follows another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_one | input | 1 | Advance request line, one-step weight |
| adv_two | input | 1 | Advance request line, adds a second step |
| ret_one | input | 1 | Retard request line, one-step weight |
| ret_two | input | 1 | Retard request line, adds a second step |
| mag_a | output | 1 | First magnitude pulse output |
| pol_a | output | 1 | First polarity pulse output |
| mag_b | output | 1 | Second magnitude pulse output |
| pol_b | output | 1 | Second polarity pulse output |

## Verification
The hardest case to reach is a shift whose effect must be told apart from the slot in which it lands. An injected count can fall anywhere within a quarter cycle, and this changes which gap shrinks. The stimulus therefore starts each request in the middle of a control period and holds it across exactly one sampling edge. The scoreboard then compares the span of the pulse train against a 4-per-pulse count corrected by the expected shift, and this comparison does not depend on slot position. The off-edge case uses a one-cycle request placed well away from a sampling edge.

// File: rtl/rot_pkg.sv
package rot_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int SHIFT_W = 3;
  typedef logic signed [SHIFT_W-1:0] shift_t;

  // per-cycle divider increment: hold swallows a count, two injects one
  typedef enum logic [1:0] {STEP_HOLD = 2'd0, STEP_ONE = 2'd1, STEP_TWO = 2'd2} step_e;

  // combine request lines; opposing requests cancel to zero
  function automatic shift_t net_request(input logic a1, input logic a2,
                                         input logic r1, input logic r2);
    logic [1:0] adv;
    logic [1:0] ret;
    adv = {1'b0, a1} + {1'b0, a2};
    ret = {1'b0, r1} + {1'b0, r2};
    if (adv != 2'd0 && ret != 2'd0) return shift_t'(0);
    if (adv != 2'd0) return shift_t'({1'b0, adv});
    return shift_t'(3'd0 - {1'b0, ret});
  endfunction
endpackage

// File: rtl/rot_ctrl_sync.sv
module rot_ctrl_sync
  import rot_pkg::*;
#(
  parameter int DIV_LOG2 = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv_one,
  input  logic   adv_two,
  input  logic   ret_one,
  input  logic   ret_two,
  output shift_t cmd,
  output logic   commit
);
  timeunit 1ns; timeprecision 1ps;

  logic [DIV_LOG2-1:0] sc;
  shift_t              last_q;

  // free-running sub-harmonic source
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc <= '0;
    else        sc <= sc + 1'b1;
  end

  // latch chain: stage j is enabled at rate master/2^(DIV_LOG2-j)
  for (genvar j = 0; j < DIV_LOG2; j++) begin : g_stage
    shift_t q;
    logic   en;
    assign en = &sc[DIV_LOG2-1-j:0];
    if (j == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= net_request(adv_one, adv_two, ret_one, ret_two);
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= g_stage[j-1].q;
      end
    end
  end

  // final read by the master clock itself
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= g_stage[DIV_LOG2-1].q;
  end

  assign cmd    = last_q;
  assign commit = &sc;
endmodule

// File: rtl/rot_shift.sv
module rot_shift
  import rot_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   commit,
  input  shift_t cmd,
  output step_e  step,
  output shift_t pend
);
  timeunit 1ns; timeprecision 1ps;

  shift_t pend_q;

  always_comb begin
    if (pend_q > 0)      step = STEP_TWO;
    else if (pend_q < 0) step = STEP_HOLD;
    else                 step = STEP_ONE;
  end

  // one master-clock unit of shift is consumed per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= '0;
    else if (commit)     pend_q <= cmd;
    else if (pend_q > 0) pend_q <= shift_t'(pend_q - 3'sd1);
    else if (pend_q < 0) pend_q <= shift_t'(pend_q + 3'sd1);
  end

  assign pend = pend_q;
endmodule

// File: rtl/rot_divider.sv
module rot_divider
  import rot_pkg::*;
#(
  parameter int DIV_LOG2   = 4,
  parameter bit EQUAL_RATE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  step_e      step,
  output logic [3:0] ph
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CW = DIV_LOG2 + 1;   // one extra stage for half-rate polarity
  localparam int LO = DIV_LOG2 - 2;   // quarter-cycle boundary bit

  logic [CW-1:0] cnt, nxt;
  logic          fire, half_ok;
  logic [1:0]    slot;
  logic [3:0]    ph_d, ph_q;

  assign nxt  = cnt + CW'(step);
  assign fire = nxt[CW-1:LO] != cnt[CW-1:LO];
  assign slot = nxt[DIV_LOG2-1:LO];

  if (EQUAL_RATE) begin : g_equal
    assign half_ok = 1'b1;
  end else begin : g_half
    assign half_ok = ~nxt[CW-1];
  end

  // channel c fires on slot c+1; odd channels are polarity
  for (genvar c = 0; c < 4; c++) begin : g_ch
    if (c % 2 == 1) begin : g_pol
      assign ph_d[c] = fire && (slot == 2'((c + 1) % 4)) && half_ok;
    end else begin : g_mag
      assign ph_d[c] = fire && (slot == 2'((c + 1) % 4));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ph_q <= '0;
    end else begin
      cnt  <= nxt;
      ph_q <= ph_d;
    end
  end

  assign ph = ph_q;
endmodule

// File: rtl/phase_rotator.sv
module phase_rotator
  import rot_pkg::*;
#(
  parameter int DIV_LOG2   = 4,
  parameter bit EQUAL_RATE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_one,
  input  logic adv_two,
  input  logic ret_one,
  input  logic ret_two,
  output logic mag_a,
  output logic pol_a,
  output logic mag_b,
  output logic pol_b
);
  timeunit 1ns; timeprecision 1ps;

  shift_t     cmd, pend_q;
  logic       commit;
  step_e      step;
  logic [3:0] ph;

  rot_ctrl_sync #(.DIV_LOG2(DIV_LOG2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .adv_one(adv_one), .adv_two(adv_two),
    .ret_one(ret_one), .ret_two(ret_two),
    .cmd(cmd), .commit(commit)
  );

  rot_shift u_shift (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cmd(cmd),
    .step(step), .pend(pend_q)
  );

  rot_divider #(.DIV_LOG2(DIV_LOG2), .EQUAL_RATE(EQUAL_RATE)) u_div (
    .clk(clk), .rst_n(rst_n), .step(step), .ph(ph)
  );

  assign mag_a = ph[0];
  assign pol_a = ph[1];
  assign mag_b = ph[2];
  assign pol_b = ph[3];
endmodule

// File: rtl/rot_checker.sv
module rot_checker
  import rot_pkg::*;
#(
  parameter bit EQUAL_RATE = 1'b1
) (
  input logic   clk,
  input logic   rst_n,
  input logic   mag_a,
  input logic   pol_a,
  input logic   mag_b,
  input logic   pol_b,
  input logic   commit,
  input shift_t pend
);
  timeunit 1ns; timeprecision 1ps;

  localparam int GMAX = EQUAL_RATE ? 6 : 10;

  logic [3:0] ph;
  logic [1:0] ch, last_ch;
  logic [3:0] gap;
  logic       seen;

  assign ph = {pol_b, mag_b, pol_a, mag_a};

  always_comb begin
    case (ph)
      4'b0010: ch = 2'd1;
      4'b0100: ch = 2'd2;
      4'b1000: ch = 2'd3;
      default: ch = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; last_ch <= 2'd0; gap <= 4'd0;
    end else if (|ph) begin
      seen <= 1'b1; last_ch <= ch; gap <= 4'd1;
    end else if (gap != 4'd15) begin
      gap <= gap + 4'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) a_r1_quiet: assert (ph == 4'b0000);
  end

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ph));
  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n) (|ph) |=> !(|ph));
  a_r3_gap_window: assert property (@(posedge clk) disable iff (!rst_n)
    (|ph && seen) |-> (gap >= 4'd2 && gap <= 4'(GMAX)));
  a_r5_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (pend == 0));

  if (EQUAL_RATE) begin : g_order
    a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
      (|ph && seen) |-> (ch == last_ch + 2'd1));
  end
endmodule

bind phase_rotator rot_checker #(.EQUAL_RATE(EQUAL_RATE)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mag_a(mag_a), .pol_a(pol_a), .mag_b(mag_b), .pol_b(pol_b),
  .commit(commit), .pend(pend_q)
);

// File: tb/sim_phase_rotator.sv
module sim_phase_rotator;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a1 = 1'b0, a2 = 1'b0, r1 = 1'b0, r2 = 1'b0;
  logic [3:0] ph0, ph1;
  int cyc;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  phase_rotator u0 (
    .clk(clk), .rst_n(rst_n), .adv_one(a1), .adv_two(a2), .ret_one(r1), .ret_two(r2),
    .mag_a(ph0[0]), .pol_a(ph0[1]), .mag_b(ph0[2]), .pol_b(ph0[3])
  );

  phase_rotator #(.EQUAL_RATE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .adv_one(1'b0), .adv_two(1'b0), .ret_one(1'b0), .ret_two(1'b0),
    .mag_a(ph1[0]), .pol_a(ph1[1]), .mag_b(ph1[2]), .pol_b(ph1[3])
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // monitor state
  int last_t = 0, npulse = 0, last_ch = 0, first_t = -1, first_ch = -1;
  int order_bad = 0, width_bad = 0, ep_min = 1000, ep_max = 0;
  logic [3:0] prev_ph0 = 4'b0;
  int ch_last0[4] = '{-1, -1, -1, -1};
  int ch_gap0[4]  = '{0, 0, 0, 0};
  int ch_last1[4] = '{-1, -1, -1, -1};
  int ch_gap1[4]  = '{0, 0, 0, 0};

  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(ph0) > 1) width_bad++;
      if ((ph0 & prev_ph0) != 4'b0) width_bad++;
      prev_ph0 = ph0;
      if (ph0 != 4'b0) begin
        int ch;
        ch = ph0[1] ? 1 : ph0[2] ? 2 : ph0[3] ? 3 : 0;
        if (npulse == 0) begin
          first_t = cyc; first_ch = ch;
        end else begin
          if (cyc - last_t < ep_min) ep_min = cyc - last_t;
          if (cyc - last_t > ep_max) ep_max = cyc - last_t;
          if (ch != (last_ch + 1) % 4) order_bad++;
        end
        last_t = cyc; last_ch = ch; npulse++;
        if (ch_last0[ch] >= 0) ch_gap0[ch] = cyc - ch_last0[ch];
        ch_last0[ch] = cyc;
      end
      for (int c = 0; c < 4; c++) begin
        if (ph1[c]) begin
          if (ch_last1[c] >= 0) ch_gap1[c] = cyc - ch_last1[c];
          ch_last1[c] = cyc;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    int    shift;
    int    lo;
    int    hi;
    int    t0;
    int    n0;
    string tag;
  } exp_t;
  exp_t sbq[$];
  event ep_done;

  initial begin
    forever begin
      @(ep_done);
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check((last_t - e.t0) == 4 * (npulse - e.n0) - e.shift, e.tag, "stream span",
              last_t - e.t0, 4 * (npulse - e.n0) - e.shift);
        check(ep_min >= e.lo && ep_max <= e.hi, e.tag, "gap min*100+max",
              ep_min * 100 + ep_max, e.lo * 100 + e.hi);
      end
    end
  end

  task automatic episode(input bit x1, input bit x2, input bit y1, input bit y2,
                         input int hold, input int shift, input int lo, input int hi,
                         input string tag);
    do @(negedge clk); while (cyc % 16 != 8);
    ep_min = 1000; ep_max = 0;
    sbq.push_back('{shift: shift, lo: lo, hi: hi, t0: last_t, n0: npulse, tag: tag});
    a1 = x1; a2 = x2; r1 = y1; r2 = y2;
    repeat (hold) @(negedge clk);
    a1 = 1'b0; a2 = 1'b0; r1 = 1'b0; r2 = 1'b0;
    repeat (48) @(negedge clk);
    -> ep_done;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ph0 == 4'b0 && ph1 == 4'b0, "R1", "outputs in reset", int'({ph1, ph0}), 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(first_t == 4, "R1", "first pulse cycle", first_t, 4);
    check(first_ch == 0, "R1", "first pulse channel", first_ch, 0);

    episode(0, 0, 0, 0, 16,  0, 4, 4, "R2 idle");
    episode(1, 0, 0, 0, 16,  1, 3, 4, "R3 adv_one");
    episode(0, 1, 0, 0, 16,  1, 3, 4, "R3 adv_two");
    episode(0, 0, 1, 0, 16, -1, 4, 5, "R4 ret_one");
    episode(0, 0, 0, 1, 16, -1, 4, 5, "R4 ret_two");
    episode(1, 1, 0, 0, 16,  2, 2, 4, "R5 double advance");
    episode(0, 0, 1, 1, 16, -2, 4, 6, "R6 double retard");
    episode(1, 0, 1, 0, 16,  0, 4, 4, "R7 cancel single");
    episode(1, 1, 0, 1, 16,  0, 4, 4, "R7 cancel mixed");
    episode(1, 1, 0, 0,  1,  0, 4, 4, "R8 off-edge advance");
    episode(0, 0, 1, 1,  1,  0, 4, 4, "R8 off-edge retard");

    check(order_bad == 0, "R2", "cyclic order violations", order_bad, 0);
    check(width_bad == 0, "R10", "overlap or wide pulses", width_bad, 0);
    for (int c = 0; c < 4; c++)
      check(ch_gap0[c] == 16, "R9", $sformatf("equal-rate period ch%0d", c), ch_gap0[c], 16);
    for (int c = 0; c < 4; c++)
      check(ch_gap1[c] == ((c % 2 == 1) ? 32 : 16), "R9",
            $sformatf("half-rate mode period ch%0d", c), ch_gap1[c], (c % 2 == 1) ? 32 : 16);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule